// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-byte read and write requests from inside the chip into bus cycles on an external bus. The external bus shares one byte between the low address and the data. Every cycle has two phases. In the address phase the address strobe goes low and the low address byte is driven on the shared byte. The upper address bits go out on dedicated pins. In the data phase the address strobe rises and, for accesses that really go off-chip, the data strobe goes low. A programmable number of wait clocks (0 to 7) stretches the data phase. On reads the shared byte is released, and the value present when the data strobe rises becomes the read result. On writes the data is driven from the start of the data phase and held until the next address goes out.

Requests arrive on a valid/ready channel. The requester holds `req_valid_i` and the request fields steady until it sees `req_ready_o` high at a clock edge. The block samples the fields, and `cfg_wait_i`, only at that handshake edge. Ready is high only while no cycle is in progress, so one request is in flight at a time. The response cannot be held back: `rsp_valid_o` is a pulse one clock long, and the requester must take `rsp_rdata_o` in that clock.

The shared byte is split into output value, output enable and input, so that a bidirectional pad at the chip edge can carry it.

Top module: `mxbus_ctrl`

## Requirements
- R1: After reset the address strobe and the data strobe are high (1), the shared-byte enable is 0, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A request is taken at a clock edge where valid and ready are both 1. The address phase then lasts exactly one clock. In that clock the address strobe is low, the shared byte is driven with address bits [7:0], and the read/write line is set to 0 for a write or 1 for a read. The read/write line stays unchanged until the end of the cycle. Ready is 0 from the address phase until the cycle has ended.
- R3: At the edge that ends the address phase, the address strobe rises. The data strobe falls at that same edge, but only when `req_ext_i` was 1. When `req_ext_i` was 0, the data strobe stays high for the whole cycle. The two strobes are never low together.
- R4: The data phase lasts 1 + W clocks. W is the value of `cfg_wait_i` at the handshake edge, and later changes to `cfg_wait_i` do not affect the cycle. The data strobe rises at the edge that ends the data phase.
- R5: During the data phase of a read, and afterwards until the next address phase, the shared-byte enable is 0. The read result is the value of `bus_ad_i` at the edge where the data strobe rises.
- R6: For an external write, the shared byte carries the write data with the enable at 1 from the first data-phase clock. Both the data and the enable stay unchanged through the idle clocks that follow, up to the next address phase.
- R7: The upper address pins carry address bits [15:8] from the address phase on. They do not change until the next address phase.
- R8: `rsp_valid_o` is 1 for exactly one clock, the clock that follows the end of the data phase. `rsp_rdata_o` is updated only by external reads. Internal cycles do not drive data in the data phase and leave `rsp_rdata_o` unchanged.
- R9: While no request is pending, both strobes stay high and `req_ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wait_i | input | WAIT_W | Wait clocks added to the data phase, sampled at the handshake |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (no cycle in progress) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ext_i | input | 1 | 1 = access goes off-chip (data strobe used) |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | DATA_W | Last externally read byte |
| bus_as_n_o | output | 1 | Address strobe, active low |
| bus_ds_n_o | output | 1 | Data strobe, active low |
| bus_rw_n_o | output | 1 | Read/write line: 1 = read, 0 = write |
| bus_addr_hi_o | output | ADDR_W-DATA_W | Upper address bits |
| bus_ad_o | output | DATA_W | Shared byte, outgoing value |
| bus_ad_oe_o | output | 1 | Shared byte output enable |
| bus_ad_i | input | DATA_W | Shared byte, incoming value |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit shared byte and a 3-bit wait field. With a 3-bit field, both the shortest data phase (no wait) and the longest (seven waits) can be reached. The bench drives a wrong value on the input byte in every data clock except the last. This shows that the read result comes from the strobe-rising edge and not from an earlier clock. The bench also changes the wait setting in mid-cycle, follows a write with idle clocks and then a read, and runs internal cycles to observe that the data strobe stays high and the read result stays unchanged.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } mxb_phase_e;
endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ext_i,
  input  logic              write_i,
  input  logic [WAIT_W-1:0] wait_i,
  output mxb_phase_e        phase_o,
  output logic              ext_o,
  output logic              last_o,
  output logic              as_n_o,
  output logic              ds_n_o,
  output logic              rw_n_o,
  output logic              done_o
);
  mxb_phase_e        phase_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] dcnt_q;
  logic              ext_q, as_n_q, ds_n_q, rw_n_q, done_q;

  assign last_o  = (phase_q == PH_DATA) && (wcnt_q == '0);
  assign phase_o = phase_q;
  assign ext_o   = ext_q;
  assign as_n_o  = as_n_q;
  assign ds_n_o  = ds_n_q;
  assign rw_n_o  = rw_n_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wcnt_q  <= '0;
      wait_q  <= '0;
      dcnt_q  <= '0;
      ext_q   <= 1'b0;
      as_n_q  <= 1'b1;
      ds_n_q  <= 1'b1;
      rw_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_ADDR;
            as_n_q  <= 1'b0;
            rw_n_q  <= ~write_i;
            ext_q   <= ext_i;
            wcnt_q  <= wait_i;
            wait_q  <= wait_i;
          end
        end
        PH_ADDR: begin
          phase_q <= PH_DATA;
          as_n_q  <= 1'b1;
          ds_n_q  <= ~ext_q;
          dcnt_q  <= '0;
        end
        PH_DATA: begin
          if (wcnt_q == '0) begin
            phase_q <= PH_IDLE;
            ds_n_q  <= 1'b1;
            done_q  <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
            dcnt_q <= dcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R3: strobes never overlap
  a_r3_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!as_n_q && !ds_n_q));
  // R3: data strobe falls only together with the address strobe rising
  a_r3_ds_after_as: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ds_n_q) |-> $rose(as_n_q));
  // R4: data phase ends after exactly the latched number of wait clocks
  a_r4_data_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_DATA) && (wcnt_q == '0)) |-> (dcnt_q == wait_q));
endmodule

// File: rtl/mxb_addr_path.sv
module mxb_addr_path
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mxb_phase_e        phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              write_i,
  input  logic              ext_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o
);
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] ad_q, wdat_q;
  logic              oe_q, drv_q;

  assign addr_hi_o = hi_q;
  assign ad_o      = ad_q;
  assign ad_oe_o   = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      ad_q   <= '0;
      wdat_q <= '0;
      oe_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else if ((phase_i == PH_IDLE) && start_i) begin
      hi_q   <= addr_i[ADDR_W-1:DATA_W];
      ad_q   <= addr_i[DATA_W-1:0];
      oe_q   <= 1'b1;
      wdat_q <= wdata_i;
      drv_q  <= ext_i && write_i;
    end else if (phase_i == PH_ADDR) begin
      ad_q <= wdat_q;
      oe_q <= drv_q;
    end
  end

  // R7: upper address changes only right after a handshake
  a_r7_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> $stable(addr_hi_o));
endmodule

// File: rtl/mxb_rd_capture.sv
module mxb_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_q;
  assign rdata_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (sample_i) rd_q <= ad_i;
  end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_ext_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              bus_as_n_o,
  output logic              bus_ds_n_o,
  output logic              bus_rw_n_o,
  output logic [HI_W-1:0]   bus_addr_hi_o,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  input  logic [DATA_W-1:0] bus_ad_i
);
  mxb_phase_e phase;
  logic       start, ext_cur, last, sample;

  assign req_ready_o = (phase == PH_IDLE);
  assign start       = req_valid_i && req_ready_o;
  assign sample      = last && ext_cur && bus_rw_n_o;

  mxb_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ext_i   (req_ext_i),
    .write_i (req_write_i),
    .wait_i  (cfg_wait_i),
    .phase_o (phase),
    .ext_o   (ext_cur),
    .last_o  (last),
    .as_n_o  (bus_as_n_o),
    .ds_n_o  (bus_ds_n_o),
    .rw_n_o  (bus_rw_n_o),
    .done_o  (rsp_valid_o)
  );

  mxb_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .phase_i   (phase),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .write_i   (req_write_i),
    .ext_i     (req_ext_i),
    .addr_hi_o (bus_addr_hi_o),
    .ad_o      (bus_ad_o),
    .ad_oe_o   (bus_ad_oe_o)
  );

  mxb_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .ad_i     (bus_ad_i),
    .rdata_o  (rsp_rdata_o)
  );

  // R5: shared byte is released whenever a read data strobe is low
  a_r5_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ds_n_o && bus_rw_n_o) |-> !bus_ad_oe_o);
  // R8: completion pulse is one clock long
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9: while ready, no strobe is active
  a_r9_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bus_as_n_o && bus_ds_n_o));
  // R2: read/write line is steady from the address phase to the data phase
  a_r2_rw_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_as_n_o) |=> $stable(bus_rw_n_o));
endmodule

// File: tb/mxbus_ctrl_tb_top.sv
module mxbus_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_wait = '0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, ad_in = '0;
  logic       req_ready, rsp_valid, as_n, ds_n, rw_n, ad_oe;
  logic [7:0] rsp_rdata, addr_hi, ad_out;
  logic [7:0] exp_rd = '0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mxbus_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wait_i(cfg_wait),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_ext_i(req_ext), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_as_n_o(as_n), .bus_ds_n_o(ds_n), .bus_rw_n_o(rw_n),
    .bus_addr_hi_o(addr_hi), .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe),
    .bus_ad_i(ad_in)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "as_n", as_n, 1);
    chk("R1", "ds_n", ds_n, 1);
    chk("R1", "oe", ad_oe, 0);
    chk("R1", "ready", req_ready, 1);
    chk("R1", "rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_cycle(input logic [15:0] a, input logic [7:0] wd, input bit wr,
                         input bit ext, input logic [2:0] wt, input logic [7:0] rb);
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_write = wr; req_ext = ext;
    cfg_wait = wt; req_valid = 1'b1; ad_in = ~rb;
    @(negedge clk);
    req_valid = 1'b0; cfg_wait = ~wt;
    chk("R2", "T1 as_n", as_n, 0);
    chk("R2", "T1 oe", ad_oe, 1);
    chk("R2", "T1 low addr", ad_out, a[7:0]);
    chk("R2", "T1 rw_n", rw_n, !wr);
    chk("R2", "T1 ready", req_ready, 0);
    chk("R3", "T1 ds_n", ds_n, 1);
    chk("R7", "T1 addr_hi", addr_hi, a[15:8]);
    for (int k = 0; k <= wt; k++) begin
      @(negedge clk);
      chk("R3", "T2 as_n", as_n, 1);
      chk("R3", "T2 ds_n", ds_n, !ext);
      chk("R2", "T2 rw_n", rw_n, !wr);
      chk("R7", "T2 addr_hi", addr_hi, a[15:8]);
      if (wr && ext) begin
        chk("R6", "T2 oe", ad_oe, 1);
        chk("R6", "T2 data", ad_out, wd);
      end else begin
        chk("R5", "T2 released", ad_oe, 0);
      end
      chk("R8", "T2 no done", rsp_valid, 0);
      ad_in = (k == int'(wt)) ? rb : ~rb;
    end
    if (ext && !wr) exp_rd = rb;
    @(negedge clk);
    ad_in = ~rb;
    chk("R4", "ds_n risen", ds_n, 1);
    chk("R8", "done", rsp_valid, 1);
    chk("R5", "rdata", rsp_rdata, exp_rd);
    chk("R6", "oe after", ad_oe, wr && ext);
    chk("R9", "ready after", req_ready, 1);
    @(negedge clk);
    chk("R8", "done one clock", rsp_valid, 0);
    chk("R7", "hi hold idle", addr_hi, a[15:8]);
    chk("R6", "oe hold idle", ad_oe, wr && ext);
    if (wr && ext) chk("R6", "data hold idle", ad_out, wd);
  endtask

  task automatic t_idle(input int n, input bit exp_oe);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9", "idle as_n", as_n, 1);
      chk("R9", "idle ds_n", ds_n, 1);
      chk("R9", "idle ready", req_ready, 1);
      chk("R5", "idle oe", ad_oe, exp_oe);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_idle(3, 0);
    t_cycle(16'h12A5, 8'h00, 0, 1, 3'd0, 8'h3C);   // R5 external read, no wait
    t_cycle(16'hBEEF, 8'h00, 0, 1, 3'd3, 8'hC7);   // R4 wait 3
    t_cycle(16'h4481, 8'h5A, 1, 1, 3'd0, 8'h00);   // R6 external write
    t_idle(3, 1);                                  // R6 data held while idle
    t_cycle(16'h9A0F, 8'h00, 0, 1, 3'd7, 8'h81);   // R4 max wait
    t_cycle(16'h0F33, 8'hE1, 1, 0, 3'd2, 8'h00);   // R3 internal write
    t_cycle(16'h7710, 8'h00, 0, 0, 3'd1, 8'h99);   // R8 internal read keeps rdata
    t_idle(2, 0);
    t_cycle(16'hFFFE, 8'hA6, 1, 1, 3'd7, 8'h00);   // R6 write, max wait
    t_cycle(16'h0001, 8'h00, 0, 1, 3'd5, 8'h42);   // R5 read after write
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule